// File: doc/BRIEF.md
# Monitor Word Serial Transmitter

This block sends a snapshot of four 32-bit monitor words out of the chip on one data pin. A second pin marks which cycles carry valid data bits. A flag pin pulses on the first bit of each word. A transfer starts when the acquisition sequencer enters its frame sync state, signalled on `sync_i`. All four words are captured on that cycle. They then leave back-to-back, one bit per fast-clock cycle, each word starting with its least-significant bit and ending with its sign bit.

Every transfer fills a fixed window of 140 cycles: 128 data cycles followed by 12 quiet cycles. The whole transfer therefore ends well before the next compute pass. A one-cycle done pulse follows the window. A sync request that arrives while a window is running has no effect. This lets the sequencer hold or repeat the request without corrupting the stream.

Top module: `mon_serial_tx`

## Requirements
- R1: While `rst_ni` is low, and in every idle cycle after reset, `ser_data_o`, `ser_qual_o`, `flag_o` and `done_o` are all low.
- R2: When `sync_i` is high at a clock edge while idle, the transfer starts. In the next cycle (window cycle 0), `ser_qual_o` is high and `ser_data_o` carries bit 0 of word 0.
- R3: In window cycle i, for i from 0 to 127, `ser_data_o` equals bit i mod 32 of word i div 32. Word n sits at `words_i[32n+31:32n]`, so this is bit i of the flat `words_i` vector captured at the start. Words go out in the order 0 to 3, with no gaps, and `ser_qual_o` stays high for all 128 cycles.
- R4: `flag_o` is high exactly in window cycles 0, 32, 64 and 96, which are the bit-0 cycles of the four words. It is low in every other cycle.
- R5: Window cycles 128 to 139 are quiet: `ser_data_o`, `ser_qual_o` and `flag_o` are low. The window lasts 140 cycles in total.
- R6: `done_o` is high for exactly one cycle, the cycle right after window cycle 139. It is low at all other times.
- R7: `words_i` is sampled only on the start cycle. Changes to it during a window do not change the bits sent.
- R8: A high `sync_i` during window cycles 0 to 139 is ignored. It neither restarts nor extends the window, and the cycle after the done pulse is idle.
- R9: If `sync_i` is high in the done cycle, a new window starts in the following cycle. This means that a `sync_i` held high gives back-to-back transfers spaced 141 cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Frame sync request from the acquisition sequencer |
| words_i | input | 128 | Four monitor words, word n at bits 32n+31:32n |
| ser_data_o | output | 1 | Serial data bit |
| ser_qual_o | output | 1 | High in cycles that carry a valid data bit |
| flag_o | output | 1 | High on bit 0 of each word |
| done_o | output | 1 | One-cycle pulse after the window ends |

## Verification
The main function is tried with several kinds of word patterns:
- All-zero and all-one words separate the data path from the qualifier and flag timing.
- Alternating-bit words expose off-by-one shift errors.
- A walking one, swept across all 128 bit positions, pins down each bit's exact cycle. It also tells a reversed bit order or a swapped word order apart from a correct stream.
- Arithmetic-progression words add mixed content.

Some transfers alter `words_i` and pulse `sync_i` mid-window and on the final window cycle, which separates capture from pass-through and shows that requests during a window are ignored. A held request checks the back-to-back restart.

// File: rtl/mon_tx_pkg.sv
package mon_tx_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_DATA = 2'd1,
    PH_TAIL = 2'd2
  } tx_phase_e;
endpackage

// File: rtl/mon_tx_ctrl.sv
module mon_tx_ctrl
  import mon_tx_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 4,
  parameter int WINDOW    = 140,
  localparam int BIT_W    = (WORD_W > 1) ? $clog2(WORD_W) : 1,
  localparam int WIDX_W   = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_i,
  output tx_phase_e         phase_o,
  output logic [BIT_W-1:0]  bit_idx_o,
  output logic [WIDX_W-1:0] word_idx_o,
  output logic              load_o,
  output logic              shift_o,
  output logic              done_o
);
  localparam int  BITS     = WORD_W * NUM_WORDS;
  localparam int  TAIL     = WINDOW - BITS;
  localparam bit  HAS_TAIL = (TAIL > 0);
  localparam int  TAIL_W   = (TAIL > 1) ? $clog2(TAIL) : 1;

  tx_phase_e          phase_q;
  logic [BIT_W-1:0]   bit_q;
  logic [WIDX_W-1:0]  word_q;
  logic [TAIL_W-1:0]  tail_q;
  logic               done_q;
  logic               last_bit, last_word, last_tail;

  assign last_bit  = (bit_q == BIT_W'(WORD_W - 1));
  assign last_word = (word_q == WIDX_W'(NUM_WORDS - 1));
  assign last_tail = (tail_q == TAIL_W'(HAS_TAIL ? TAIL - 1 : 0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      bit_q   <= '0;
      word_q  <= '0;
      tail_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: begin
          if (sync_i) begin
            phase_q <= PH_DATA;
            bit_q   <= '0;
            word_q  <= '0;
          end
        end
        PH_DATA: begin
          if (last_bit) begin
            bit_q <= '0;
            if (last_word) begin
              tail_q <= '0;
              if (HAS_TAIL) begin
                phase_q <= PH_TAIL;
              end else begin
                phase_q <= PH_IDLE;
                done_q  <= 1'b1;
              end
            end else begin
              word_q <= word_q + 1'b1;
            end
          end else begin
            bit_q <= bit_q + 1'b1;
          end
        end
        PH_TAIL: begin
          if (last_tail) begin
            phase_q <= PH_IDLE;
            done_q  <= 1'b1;
          end else begin
            tail_q <= tail_q + 1'b1;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o    = phase_q;
  assign bit_idx_o  = bit_q;
  assign word_idx_o = word_q;
  assign load_o     = (phase_q == PH_IDLE) && sync_i;
  assign shift_o    = (phase_q == PH_DATA);
  assign done_o     = done_q;
endmodule

// File: rtl/mon_tx_bank.sv
module mon_tx_bank #(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 4,
  localparam int WIDX_W   = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          load_i,
  input  logic                          shift_i,
  input  logic [WIDX_W-1:0]             word_idx_i,
  input  logic [NUM_WORDS*WORD_W-1:0]   words_i,
  output logic                          bit_o
);
  logic [WORD_W-1:0] word_q [NUM_WORDS];
  logic [NUM_WORDS-1:0] lsb;

  // each word only shifts while it is the one on the wire
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        word_q[w] <= '0;
      end else if (load_i) begin
        word_q[w] <= words_i[w*WORD_W +: WORD_W];
      end else if (shift_i && (word_idx_i == WIDX_W'(w))) begin
        word_q[w] <= {1'b0, word_q[w][WORD_W-1:1]};
      end
    end
    assign lsb[w] = word_q[w][0];
  end

  always_comb begin
    bit_o = 1'b0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (word_idx_i == WIDX_W'(w)) bit_o = lsb[w];
    end
  end
endmodule

// File: rtl/mon_tx_out.sv
module mon_tx_out
  import mon_tx_pkg::*;
#(
  parameter int WORD_W  = 32,
  localparam int BIT_W  = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
  input  tx_phase_e        phase_i,
  input  logic [BIT_W-1:0] bit_idx_i,
  input  logic             bank_bit_i,
  output logic             ser_data_o,
  output logic             ser_qual_o,
  output logic             flag_o
);
  logic in_data;
  assign in_data    = (phase_i == PH_DATA);
  assign ser_qual_o = in_data;
  assign ser_data_o = in_data & bank_bit_i;
  assign flag_o     = in_data & (bit_idx_i == '0);
endmodule

// File: rtl/mon_serial_tx.sv
module mon_serial_tx
  import mon_tx_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 4,
  parameter int WINDOW    = 140
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        sync_i,
  input  logic [NUM_WORDS*WORD_W-1:0] words_i,
  output logic                        ser_data_o,
  output logic                        ser_qual_o,
  output logic                        flag_o,
  output logic                        done_o
);
  localparam int BIT_W  = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam int WIDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

  tx_phase_e         phase;
  logic [BIT_W-1:0]  bit_idx;
  logic [WIDX_W-1:0] word_idx;
  logic              load, shift, bank_bit;

  mon_tx_ctrl #(
    .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .WINDOW(WINDOW)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sync_i     (sync_i),
    .phase_o    (phase),
    .bit_idx_o  (bit_idx),
    .word_idx_o (word_idx),
    .load_o     (load),
    .shift_o    (shift),
    .done_o     (done_o)
  );

  mon_tx_bank #(
    .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)
  ) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .shift_i    (shift),
    .word_idx_i (word_idx),
    .words_i    (words_i),
    .bit_o      (bank_bit)
  );

  mon_tx_out #(
    .WORD_W(WORD_W)
  ) u_out (
    .phase_i    (phase),
    .bit_idx_i  (bit_idx),
    .bank_bit_i (bank_bit),
    .ser_data_o (ser_data_o),
    .ser_qual_o (ser_qual_o),
    .flag_o     (flag_o)
  );
endmodule

// File: rtl/mon_tx_chk.sv
module mon_tx_chk #(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 4,
  parameter int WINDOW    = 140
) (
  input logic clk_i,
  input logic rst_ni,
  input logic ser_data_o,
  input logic ser_qual_o,
  input logic flag_o,
  input logic done_o
);
  localparam int BITS = WORD_W * NUM_WORDS;
  localparam int CW   = $clog2(WINDOW + 2);
  localparam int FW   = $clog2(NUM_WORDS + 2);

  logic [CW-1:0] win_cnt, run_cnt;
  logic [FW-1:0] flag_cnt;
  logic          qual_prev, start;

  assign start = ser_qual_o && !qual_prev && (win_cnt == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_cnt   <= '0;
      run_cnt   <= '0;
      flag_cnt  <= '0;
      qual_prev <= 1'b0;
    end else begin
      qual_prev <= ser_qual_o;
      run_cnt   <= ser_qual_o ? run_cnt + 1'b1 : '0;
      if (done_o)                win_cnt <= '0;
      else if (start)            win_cnt <= CW'(1);
      else if (win_cnt != '0)    win_cnt <= win_cnt + 1'b1;
      if (done_o)                flag_cnt <= '0;
      else if (flag_o)           flag_cnt <= flag_cnt + 1'b1;
    end
  end

  AST_FLAG_IN_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o |-> ser_qual_o); // R4
  AST_FLAG_ON_WORD_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o |-> ((run_cnt % CW'(WORD_W)) == '0)); // R4
  AST_DATA_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ser_qual_o |-> !ser_data_o); // R5
  AST_DATA_RUN_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ser_qual_o) |-> (run_cnt == CW'(BITS))); // R3
  AST_WINDOW_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (win_cnt == CW'(WINDOW))); // R5
  AST_FLAG_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (flag_cnt == FW'(NUM_WORDS))); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R6
  AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!ser_qual_o && !flag_o)); // R6
endmodule

bind mon_serial_tx mon_tx_chk #(
  .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .WINDOW(WINDOW)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ser_data_o (ser_data_o),
  .ser_qual_o (ser_qual_o),
  .flag_o     (flag_o),
  .done_o     (done_o)
);

// File: tb/mon_serial_tx_bench.sv
`timescale 1ns/1ps
module mon_serial_tx_bench;
  localparam int WORD_W    = 32;
  localparam int NUM_WORDS = 4;
  localparam int WINDOW    = 140;
  localparam int BITS      = WORD_W * NUM_WORDS;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            sync = 1'b0;
  logic [BITS-1:0] words = '0;
  logic            ser_data, ser_qual, flag, done;
  int              checks = 0;
  int              failures = 0;

  always #2.5 clk = ~clk;

  mon_serial_tx #(
    .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .WINDOW(WINDOW)
  ) u_mon_serial_tx (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .sync_i     (sync),
    .words_i    (words),
    .ser_data_o (ser_data),
    .ser_qual_o (ser_qual),
    .flag_o     (flag),
    .done_o     (done)
  );

  task automatic chk(input logic got, input logic exp, input string req,
                     input string what, input int cyc);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s cycle %0d: actual=%0b expected=%0b", req, what, cyc, got, exp);
    end
  endtask

  task automatic chk_idle(input string req, input int cyc);
    chk(ser_data, 1'b0, req, "data", cyc);
    chk(ser_qual, 1'b0, req, "qual", cyc);
    chk(flag,     1'b0, req, "flag", cyc);
    chk(done,     1'b0, req, "done", cyc);
  endtask

  // called at a negedge inside idle; returns at the negedge of window cycle 0
  task automatic start_xfer(input logic [BITS-1:0] w);
    words = w;
    sync  = 1'b1;
    @(negedge clk);
  endtask

  // perturb: change words and pulse sync mid-window (R7, R8); keep: hold sync high (R9)
  task automatic run_window(input logic [BITS-1:0] w, input bit perturb, input bit keep);
    for (int i = 0; i < WINDOW; i++) begin
      bit    in_data = (i < BITS);
      string dreq;
      if (!in_data)              dreq = "R5";
      else if (perturb && i > 3) dreq = "R7";
      else if (i == 0)           dreq = "R2";
      else                       dreq = "R3";
      chk(ser_data, in_data ? w[i] : 1'b0, dreq, "data", i);
      chk(ser_qual, in_data, in_data ? "R3" : "R5", "qual", i);
      chk(flag, in_data && (i % WORD_W == 0), "R4", "flag", i);
      chk(done, 1'b0, "R6", "done", i);
      if (!keep) begin
        if (i == 0) sync = 1'b0;
        if (perturb) begin
          if (i == 3) words = ~w;
          if (i == 50 || i == WINDOW - 1) sync = 1'b1;
          if (i == 51) sync = 1'b0;
        end
      end
      @(negedge clk);
    end
    chk(done, 1'b1, "R6", "done", WINDOW);
    chk(ser_qual, 1'b0, "R6", "qual", WINDOW);
    chk(flag, 1'b0, "R6", "flag", WINDOW);
    if (!keep) begin
      sync = 1'b0;
      @(negedge clk);
      chk(done, 1'b0, "R6", "done", WINDOW + 1);
      chk(ser_qual, 1'b0, "R8", "qual", WINDOW + 1);
      chk(flag, 1'b0, "R8", "flag", WINDOW + 1);
    end else begin
      @(negedge clk);
      chk(ser_qual, 1'b1, "R9", "qual", WINDOW + 1);
      chk(flag, 1'b1, "R9", "flag", WINDOW + 1);
    end
  endtask

  function automatic logic [BITS-1:0] arith_words(input int seed);
    logic [BITS-1:0] v;
    for (int n = 0; n < NUM_WORDS; n++)
      v[n*WORD_W +: WORD_W] = 32'h9E37_79B9 * (seed + n + 1) + 32'h0101_0101 * n;
    return v;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1: quiet in reset even with a request pending
    words = {BITS{1'b1}};
    sync  = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk_idle("R1", 0);
    end
    sync  = 1'b0;
    rst_n = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk_idle("R1", 0);
    end

    start_xfer('0);                     run_window('0, 0, 0);
    start_xfer({BITS{1'b1}});           run_window({BITS{1'b1}}, 0, 0);
    start_xfer({(BITS/2){2'b01}});      run_window({(BITS/2){2'b01}}, 0, 0);
    start_xfer({(BITS/2){2'b10}});      run_window({(BITS/2){2'b10}}, 0, 0);

    // R3: walking one over every bit position
    for (int b = 0; b < BITS; b++) begin
      logic [BITS-1:0] w = '0;
      w[b] = 1'b1;
      start_xfer(w);
      run_window(w, 0, 0);
    end

    // R7, R8: inputs changed and requests raised during the window
    for (int s = 0; s < 4; s++) begin
      start_xfer(arith_words(s));
      run_window(arith_words(s), 1, 0);
    end

    // R9: held request gives back-to-back windows
    start_xfer(arith_words(10));
    run_window(arith_words(10), 0, 1);
    words = arith_words(11);
    @(negedge clk);
    // second window began one cycle earlier; its cycle 0 was checked above
    for (int i = 1; i < WINDOW; i++) begin
      chk(ser_data, (i < BITS) ? arith_words(10)[i] : 1'b0, "R9", "data", i);
      @(negedge clk);
    end
    sync = 1'b0;
    chk(done, 1'b1, "R9", "done", WINDOW);
    @(negedge clk);
    chk_idle("R1", WINDOW + 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule